// File: doc/BRIEF.md
# Signal Presence Detector with Hysteresis

This block decides whether an in-band signal is present on the line. It receives a stream of digital magnitude estimates of the already filtered line signal, qualified by a sample strobe. It compares each estimate against a pair of thresholds chosen by the operating mode, either FSK receive or tone alert. A presence flag changes only after a run of consecutive qualifying samples, so the flag does not chatter when the level sits near a threshold.

Each mode has its own pick-up threshold, drop-out threshold, turn-on run length and turn-off run length. The drop-out threshold lies below the pick-up threshold, which gives amplitude hysteresis. The separate run lengths give time hysteresis. In FSK receive mode the flag drives the external detect output. In tone-alert mode the flag goes to the tone-alert decision logic on a separate output, and the external detect output stays low. A change of mode discards any pending run and forces the flag low.

Top module: `sig_presence_det`

## Requirements
- R1: While reset is asserted and after its release, before any qualifying run, both `det_fsk` and `tone_lvl` are 0.
- R2: In FSK mode (`mode_tone`=0), the flag rises at the clock edge that samples the FSK_TON-th consecutive strobed sample with `level` >= FSK_ON. It does not rise earlier.
- R3: In tone-alert mode (`mode_tone`=1), pick-up uses TONE_ON and TONE_TON instead. A level that passes the FSK pick-up threshold but is below TONE_ON never raises the flag.
- R4: While the flag is high, it falls at the edge that samples the n-th consecutive strobed sample below the drop-out threshold. Here n is FSK_TOFF with threshold FSK_OFF in FSK mode, or TONE_TOFF with threshold TONE_OFF in tone mode.
- R5: A strobed sample between the drop-out and pick-up thresholds keeps the current flag value and restarts the pending run toward the opposite state.
- R6: Cycles with `level_vld`=0 neither advance nor restart a pending run, and they never raise the flag.
- R7: A cycle where `mode_tone` differs from the previously sampled mode clears the flag at that edge. It also discards the pending run, and the sample in that cycle is ignored.
- R8: `det_fsk` carries the flag only in FSK mode and `tone_lvl` carries it only in tone mode. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tone | input | 1 | 0 selects FSK receive, 1 selects tone alert |
| level | input | LW | Magnitude estimate of the filtered signal |
| level_vld | input | 1 | Strobe marking `level` as a new sample |
| det_fsk | output | 1 | Presence flag driven to the external detect pin in FSK mode |
| tone_lvl | output | 1 | Presence flag to the tone-alert decision logic in tone mode |

## Verification
The bench targets runs that are one sample short of the terminal count. A design with an off-by-one error would switch a sample early there, or one sample late. A single sample between the thresholds is placed inside a run. A design that does not restart the run would switch too early, and a design that treats that sample as a crossing would flip the flag. Runs are split by idle strobe cycles to catch a counter that resets or advances without a strobe. Mode switches are made while the flag is high and while a strobed high sample is present, to catch an output leaking across modes or a switch-cycle sample being counted.

// File: rtl/sig_presence_det.sv
module sig_presence_det #(
  parameter int LW        = 12,
  parameter int FSK_ON    = 600,
  parameter int FSK_OFF   = 400,
  parameter int FSK_TON   = 8,
  parameter int FSK_TOFF  = 12,
  parameter int TONE_ON   = 900,
  parameter int TONE_OFF  = 700,
  parameter int TONE_TON  = 5,
  parameter int TONE_TOFF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_tone,
  input  logic [LW-1:0] level,
  input  logic          level_vld,
  output logic          det_fsk,
  output logic          tone_lvl
);
  localparam int MAX_A = (FSK_TON > FSK_TOFF) ? FSK_TON : FSK_TOFF;
  localparam int MAX_B = (TONE_TON > TONE_TOFF) ? TONE_TON : TONE_TOFF;
  localparam int TMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(TMAX + 1);

  logic          mode_q, present;
  logic [CW-1:0] pend;

  wire [LW-1:0] th_on   = mode_tone ? LW'(TONE_ON)  : LW'(FSK_ON);
  wire [LW-1:0] th_off  = mode_tone ? LW'(TONE_OFF) : LW'(FSK_OFF);
  wire [CW-1:0] n_on    = mode_tone ? CW'(TONE_TON)  : CW'(FSK_TON);
  wire [CW-1:0] n_off   = mode_tone ? CW'(TONE_TOFF) : CW'(FSK_TOFF);

  wire          mode_chg = mode_tone != mode_q;
  wire          toward   = present ? (level < th_off) : (level >= th_on);
  wire [CW-1:0] target   = present ? n_off : n_on;
  wire [CW:0]   pend_nx  = {1'b0, pend} + 1'b1;
  wire          hit      = pend_nx >= {1'b0, target};
  wire          sat      = &pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      present <= 1'b0;
      pend    <= '0;
    end else if (mode_chg) begin
      mode_q  <= mode_tone;
      present <= 1'b0;
      pend    <= '0;
    end else if (level_vld) begin
      if (!toward) begin
        pend <= '0;
      end else if (hit) begin
        present <= ~present;
        pend    <= '0;
      end else if (!sat) begin
        pend <= pend_nx[CW-1:0];
      end
    end
  end

  assign det_fsk  = present & ~mode_q;
  assign tone_lvl = present &  mode_q;
endmodule

// File: rtl/sig_presence_det_chk.sv
module sig_presence_det_chk #(
  parameter int LW       = 12,
  parameter int FSK_ON   = 600,
  parameter int FSK_OFF  = 400,
  parameter int TONE_ON  = 900,
  parameter int TONE_OFF = 700
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_tone,
  input logic [LW-1:0] level,
  input logic          level_vld,
  input logic          det_fsk,
  input logic          tone_lvl
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_fsk && tone_lvl));

  assert_mode_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_tone != $past(mode_tone)) |=> (!det_fsk && !tone_lvl));

  assert_no_idle_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !level_vld |=> !((det_fsk || tone_lvl) && !$past(det_fsk || tone_lvl)));

  assert_fsk_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_fsk) |-> ($past(level_vld) && !$past(mode_tone) && $past(level) >= LW'(FSK_ON)));

  assert_tone_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_lvl) |-> ($past(level_vld) && $past(mode_tone) && $past(level) >= LW'(TONE_ON)));

  assert_fsk_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_fsk) |-> ($past(mode_tone) || ($past(level_vld) && $past(level) < LW'(FSK_OFF))));

  assert_tone_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tone_lvl) |-> (!$past(mode_tone) || ($past(level_vld) && $past(level) < LW'(TONE_OFF))));
endmodule

bind sig_presence_det sig_presence_det_chk #(
  .LW(LW), .FSK_ON(FSK_ON), .FSK_OFF(FSK_OFF), .TONE_ON(TONE_ON), .TONE_OFF(TONE_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_tone(mode_tone), .level(level),
  .level_vld(level_vld), .det_fsk(det_fsk), .tone_lvl(tone_lvl)
);

// File: tb/sim_sig_presence_det.sv
module sim_sig_presence_det;
  localparam int LW = 12;
  localparam int F_ON = 600, F_OFF = 400, F_TON = 8, F_TOFF = 12;
  localparam int T_ON = 900, T_OFF = 700, T_TON = 5, T_TOFF = 6;

  logic clk = 1'b0, rst_n = 1'b0, mode_tone = 1'b0, level_vld = 1'b0;
  logic [LW-1:0] level = '0;
  logic det_fsk, tone_lvl;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sig_presence_det u0 (
    .clk(clk), .rst_n(rst_n), .mode_tone(mode_tone), .level(level),
    .level_vld(level_vld), .det_fsk(det_fsk), .tone_lvl(tone_lvl)
  );

  logic m_q, m_p;
  int   m_c;

  function automatic int thr(bit md, bit up);
    if (md) return up ? T_ON : T_OFF;
    return up ? F_ON : F_OFF;
  endfunction

  function automatic int runlen(bit md, bit up);
    if (md) return up ? T_TON : T_TOFF;
    return up ? F_TON : F_TOFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q <= 0; m_p <= 0; m_c <= 0;
    end else if (mode_tone != m_q) begin
      m_q <= mode_tone; m_p <= 0; m_c <= 0;
    end else if (level_vld) begin
      bit tw;
      tw = m_p ? (int'(level) < thr(mode_tone, 0)) : (int'(level) >= thr(mode_tone, 1));
      if (!tw) m_c <= 0;
      else if (m_c + 1 >= runlen(mode_tone, !m_p)) begin m_p <= !m_p; m_c <= 0; end
      else m_c <= m_c + 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic feed(int lv, bit vd, int n);
    for (int i = 0; i < n; i++) begin
      level = LW'(lv); level_vld = vd;
      @(negedge clk);
    end
  endtask

  function automatic int pick_level();
    case ($urandom_range(0, 5))
      0: return $urandom_range(0, 399);
      1: return $urandom_range(380, 620);
      2: return $urandom_range(680, 920);
      3: return $urandom_range(600, 699);
      4: return $urandom_range(900, 4095);
      default: return $urandom_range(0, 4095);
    endcase
  endfunction

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 reset det_fsk", det_fsk, 0);
    chk("R1 reset tone_lvl", tone_lvl, 0);
    rst_n = 1'b1;
    feed(0, 1, 2);
    chk("R1 after release", det_fsk | tone_lvl, 0);

    feed(700, 1, F_TON - 1);
    chk("R2 one short of turn-on", det_fsk, 0);
    feed(700, 1, 1);
    chk("R2 rise at turn-on count", det_fsk, 1);
    chk("R8 tone_lvl idle in FSK", tone_lvl, 0);

    feed(100, 1, F_TOFF - 1);
    feed(500, 1, 1);
    feed(100, 1, F_TOFF - 1);
    chk("R5 between sample restarts drop run", det_fsk, 1);
    feed(100, 1, 1);
    chk("R4 fall at turn-off count", det_fsk, 0);

    feed(700, 1, F_TON - 1);
    feed(500, 1, 1);
    chk("R5 between keeps low", det_fsk, 0);
    feed(700, 1, F_TON - 1);
    chk("R5 pick-up run restarted", det_fsk, 0);
    feed(700, 1, 1);
    chk("R2 rise after restart", det_fsk, 1);

    feed(100, 1, F_TOFF - 1);
    feed(4000, 0, 5);
    chk("R6 idle cycles keep flag", det_fsk, 1);
    feed(100, 1, 1);
    chk("R6 idle did not restart drop run", det_fsk, 0);
    for (int i = 0; i < F_TON - 1; i++) begin
      feed(700, 1, 1);
      feed(0, 0, 2);
    end
    chk("R6 interleaved idle no rise", det_fsk, 0);
    feed(700, 1, 1);
    chk("R6 run carried across idle", det_fsk, 1);

    mode_tone = 1'b1;
    feed(1000, 1, 1);
    chk("R7 switch clears det_fsk", det_fsk, 0);
    chk("R7 switch clears tone_lvl", tone_lvl, 0);
    feed(1000, 1, T_TON - 1);
    chk("R7 switch sample ignored", tone_lvl, 0);
    feed(1000, 1, 1);
    chk("R3 tone rise at its count", tone_lvl, 1);
    chk("R8 det_fsk low in tone mode", det_fsk, 0);
    feed(750, 1, T_TOFF + 2);
    chk("R4 tone holds above its drop-out", tone_lvl, 1);
    feed(600, 1, T_TOFF - 1);
    chk("R4 tone one short of drop", tone_lvl, 0 ^ 1);
    feed(600, 1, 1);
    chk("R4 tone fall", tone_lvl, 0);
    feed(800, 1, F_TON + T_TON);
    chk("R3 FSK-level input ignored in tone mode", tone_lvl, 0);

    mode_tone = 1'b0;
    feed(0, 1, 1);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) mode_tone = ~mode_tone;
      level = LW'(pick_level());
      level_vld = ($urandom_range(0, 9) < 7);
      @(negedge clk);
      chk("R8 model det_fsk", det_fsk, m_p & ~m_q);
      chk("R8 model tone_lvl", tone_lvl, m_p & m_q);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule